// File: doc/BRIEF.md
# Reset Escalation and Status Unit

This unit sits beside a chip's reset sequencer. It watches three classes of reset request: power-on, destructive and functional. It records which sources fired in sticky status registers. It also decides which kind of reset is actually issued. Functional resets are counted. Once the count meets a programmable limit, the next functional request is promoted to a destructive reset. Destructive resets are counted too. Once they meet their own limit, the unit latches a hold-in-reset output that only a new power-on event releases.

Software reaches the unit through a simple register bus. It can read the status words, the functional count and both limits. It can clear status bits by writing ones, and it can program the limits. A per-source disable word is stored and read back, but it does not gate any source. Setting a disable bit while the matching functional status bit is still set raises an interrupt flag. Every source line is a level. A reset event is its rising edge, and a status bit stays set as long as its line is high.

Top module: `rst_esc_unit`

## Requirements
- R1: After the asynchronous bus reset, both status words read 0, the functional count reads 0, the functional limit reads 15, the destructive limit reads 0, and the hold, interrupt and both reset outputs are low.
- R2: The register map uses byte offsets. 0x00 is destructive status: bit 0 is power-on, bits 1..3 are destructive sources 0..2, and bit 4 is escalation. 0x08 is functional status, with bit i for functional source i and bit 0 as the external reset. 0x0C is the disable word. 0x14 is the functional count. 0x18 is the functional limit. 0x1C is the destructive limit. The 4-bit fields sit in bits 3:0, and any other offset reads 0.
- R3: A rising edge on a functional source, with no power-on or destructive edge and no escalation, pulses func_reset_o for one cycle after that clock edge. It also adds one to the functional count, which stops at 15.
- R4: If the functional limit is nonzero and the incremented count would be at or above it, the request is promoted. dest_reset_o pulses instead of func_reset_o, and destructive status bit 4 is set.
- R5: A limit of 0 turns off escalation at its level. Functional requests then keep pulsing func_reset_o indefinitely.
- R6: When a destructive reset brings the destructive count to a nonzero destructive limit or above, hold_o goes high. It stays high until a power-on edge, and no reset pulse is issued while it is high.
- R7: Every destructive reset, whether direct or promoted, clears the functional count and reloads the functional limit to 15. It leaves the destructive limit untouched.
- R8: A power-on edge clears both counters, hold_o, the disable word and both status words. It sets the functional limit to 15 and the destructive limit to 0, and it sets destructive status bit 0.
- R9: Status bits are sticky. Writing 1 to a bit clears it only when its source line is low in that cycle.
- R10: Writing 1 to a disable bit whose functional status bit is set raises irq_o on the next cycle. irq_o stays high until the functional status word is all zero, and it falls one cycle later. A disable write that finds the matching status bit clear leaves irq_o low.
- R11: The internal destructive count stops at 15 and clears only on power-on.
- R12: Within one cycle, power-on takes priority over destructive edges, and destructive edges take priority over functional ones. Only the highest class present acts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| por_lvl | input | 1 | Power-on request level |
| dest_lvl | input | NUM_DEST | Destructive source levels |
| func_lvl | input | NUM_FUNC | Functional source levels |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| func_reset_o | output | 1 | One-cycle functional reset pulse |
| dest_reset_o | output | 1 | One-cycle destructive reset pulse |
| hold_o | output | 1 | Hold-in-reset latch |
| irq_o | output | 1 | Disable-while-pending flag |

## Verification
A functional count that is off by one shows up as a promotion one request too early or too late. That difference appears at the pulse outputs in the cycle after the offending edge, and it can be read directly from the count register. A destructive count that wraps instead of sticking at 15 stays hidden until a limit is programmed afterwards. The bench therefore drives twenty destructive edges and then sets the limit, so that hold_o exposes the wrap on the very next edge. A wrong reload or priority decision is caught by reading the limits and the status words immediately after each reset.

// File: rtl/rst_esc_pkg.sv
package rst_esc_pkg;

   // register byte offsets
   localparam int unsigned OFS_DSTAT = 32'h00;
   localparam int unsigned OFS_FSTAT = 32'h08;
   localparam int unsigned OFS_FDIS  = 32'h0C;
   localparam int unsigned OFS_FCNT  = 32'h14;
   localparam int unsigned OFS_FTHR  = 32'h18;
   localparam int unsigned OFS_DTHR  = 32'h1C;

   // class of reset acted upon in one cycle, highest priority wins
   typedef enum logic [1:0] {
      EV_NONE,
      EV_FUNC,
      EV_DEST,
      EV_POWER
   } rst_ev_e;

endpackage

// File: rtl/rst_esc_edge.sv
module rst_esc_edge #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] rise
);

   if (W < 1) begin : g_bad_w
      $error("rst_esc_edge: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic prev_bit;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_bit <= 1'b0;
         else        prev_bit <= lvl[i];
      end
      assign rise[i] = lvl[i] & ~prev_bit;
   end

endmodule

// File: rtl/rst_esc_satcnt.sv
module rst_esc_satcnt #(
   parameter int W        = 4,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt_q,
   output logic [W-1:0] cnt_nxt
);

   localparam logic [W-1:0] TOP = {W{1'b1}};

   if (W < 1) begin : g_bad_w
      $error("rst_esc_satcnt: W must be at least 1");
   end

   if (SATURATE) begin : g_sat
      assign cnt_nxt = (cnt_q == TOP) ? TOP : cnt_q + W'(1);

      // R11 and R3: a full counter never wraps
      assert_cnt_saturates_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q == TOP && inc && !clr) |=> (cnt_q == TOP))
         else $error("counter wrapped past its top");
   end else begin : g_wrap
      assign cnt_nxt = cnt_q + W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (inc) cnt_q <= cnt_nxt;
   end

   assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0))
      else $error("counter not cleared");

endmodule

// File: rtl/rst_esc_w1c.sv
module rst_esc_w1c #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_all,
   input  logic [W-1:0] set_vec,
   input  logic [W-1:0] busy_vec,
   input  logic         wr_en,
   input  logic [W-1:0] wr_mask,
   output logic [W-1:0] stat_q
);

   logic [W-1:0] kill;
   logic [W-1:0] kept;

   if (W < 1) begin : g_bad_w
      $error("rst_esc_w1c: W must be at least 1");
   end

   always_comb begin
      kill = wr_en ? (wr_mask & ~busy_vec) : '0;
      kept = clr_all ? '0 : (stat_q & ~kill);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= kept | set_vec;
   end

   // R9: a set bit whose source is still high survives any write
   assert_busy_bit_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_all |=> ((stat_q & $past(stat_q & busy_vec)) == $past(stat_q & busy_vec)))
      else $error("status bit cleared while source active");

endmodule

// File: rtl/rst_esc_unit.sv
module rst_esc_unit
   import rst_esc_pkg::*;
#(
   parameter int NUM_DEST = 3,
   parameter int NUM_FUNC = 4,
   parameter int CNT_W    = 4,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                por_lvl,
   input  logic [NUM_DEST-1:0] dest_lvl,
   input  logic [NUM_FUNC-1:0] func_lvl,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                func_reset_o,
   output logic                dest_reset_o,
   output logic                hold_o,
   output logic                irq_o
);

   localparam int DST_W   = NUM_DEST + 2;
   localparam int ESC_BIT = NUM_DEST + 1;
   localparam int DLV_W   = NUM_DEST + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (NUM_DEST < 1 || NUM_FUNC < 1) begin : g_bad_src
      $error("rst_esc_unit: need at least one source per class");
   end
   if (DST_W > DATA_W || NUM_FUNC > DATA_W || CNT_W > DATA_W) begin : g_bad_data
      $error("rst_esc_unit: fields wider than the data bus");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("rst_esc_unit: address too narrow for the map");
   end

   // ---------------- edge detection ----------------
   logic [DLV_W-1:0]    d_rise;
   logic [NUM_FUNC-1:0] f_rise;

   rst_esc_edge #(.W(DLV_W)) u_dedge (
      .clk(clk), .rst_n(rst_n), .lvl({dest_lvl, por_lvl}), .rise(d_rise));
   rst_esc_edge #(.W(NUM_FUNC)) u_fedge (
      .clk(clk), .rst_n(rst_n), .lvl(func_lvl), .rise(f_rise));

   // ---------------- registers ----------------
   logic [CNT_W-1:0]    fcnt_q, fcnt_nxt, dcnt_q, dcnt_nxt;
   logic [CNT_W-1:0]    fthr_q, dthr_q;
   logic [NUM_FUNC-1:0] fdis_q, fstat_q;
   logic [DST_W-1:0]    dstat_q;
   logic                hold_q, irq_q, frst_q, drst_q;

   // ---------------- bus decode ----------------
   logic wr_dstat, wr_fstat, wr_fdis, wr_fthr, wr_dthr;
   logic unused_wdata;

   assign wr_dstat = bus_we && (bus_addr == ADDR_W'(OFS_DSTAT));
   assign wr_fstat = bus_we && (bus_addr == ADDR_W'(OFS_FSTAT));
   assign wr_fdis  = bus_we && (bus_addr == ADDR_W'(OFS_FDIS));
   assign wr_fthr  = bus_we && (bus_addr == ADDR_W'(OFS_FTHR));
   assign wr_dthr  = bus_we && (bus_addr == ADDR_W'(OFS_DTHR));
   assign unused_wdata = ^bus_wdata;

   // ---------------- event classification ----------------
   rst_ev_e ev;
   logic    esc, dest_fire, func_fire, pwr, hold_set, irq_set;

   always_comb begin
      if (d_rise[0])                ev = EV_POWER;
      else if (hold_q)              ev = EV_NONE;
      else if (|d_rise[DLV_W-1:1])  ev = EV_DEST;
      else if (|f_rise)             ev = EV_FUNC;
      else                          ev = EV_NONE;
   end

   always_comb begin
      pwr       = (ev == EV_POWER);
      esc       = (ev == EV_FUNC) && (fthr_q != '0) && (fcnt_nxt >= fthr_q);
      dest_fire = (ev == EV_DEST) || esc;
      func_fire = (ev == EV_FUNC) && !esc;
      hold_set  = dest_fire && (dthr_q != '0) && (dcnt_nxt >= dthr_q);
      irq_set   = wr_fdis && |(bus_wdata[NUM_FUNC-1:0] & fstat_q);
   end

   // ---------------- counters ----------------
   rst_esc_satcnt #(.W(CNT_W), .SATURATE(1'b1)) u_fcnt (
      .clk(clk), .rst_n(rst_n), .clr(pwr || dest_fire), .inc(func_fire),
      .cnt_q(fcnt_q), .cnt_nxt(fcnt_nxt));

   rst_esc_satcnt #(.W(CNT_W), .SATURATE(1'b1)) u_dcnt (
      .clk(clk), .rst_n(rst_n), .clr(pwr), .inc(dest_fire),
      .cnt_q(dcnt_q), .cnt_nxt(dcnt_nxt));

   // ---------------- status words ----------------
   rst_esc_w1c #(.W(DST_W)) u_dstat (
      .clk(clk), .rst_n(rst_n), .clr_all(pwr),
      .set_vec({esc, dest_lvl, por_lvl}),
      .busy_vec({1'b0, dest_lvl, por_lvl}),
      .wr_en(wr_dstat), .wr_mask(bus_wdata[DST_W-1:0]),
      .stat_q(dstat_q));

   rst_esc_w1c #(.W(NUM_FUNC)) u_fstat (
      .clk(clk), .rst_n(rst_n), .clr_all(pwr),
      .set_vec(func_lvl), .busy_vec(func_lvl),
      .wr_en(wr_fstat), .wr_mask(bus_wdata[NUM_FUNC-1:0]),
      .stat_q(fstat_q));

   // ---------------- limits, hold, flag, outputs ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fthr_q <= CNT_MAX;
         dthr_q <= '0;
         fdis_q <= '0;
         hold_q <= 1'b0;
         irq_q  <= 1'b0;
         frst_q <= 1'b0;
         drst_q <= 1'b0;
      end else begin
         if (pwr || dest_fire) fthr_q <= CNT_MAX;
         else if (wr_fthr)     fthr_q <= bus_wdata[CNT_W-1:0];

         if (pwr)          dthr_q <= '0;
         else if (wr_dthr) dthr_q <= bus_wdata[CNT_W-1:0];

         if (pwr)          fdis_q <= '0;
         else if (wr_fdis) fdis_q <= bus_wdata[NUM_FUNC-1:0];

         if (pwr)           hold_q <= 1'b0;
         else if (hold_set) hold_q <= 1'b1;

         if (pwr) irq_q <= 1'b0;
         else     irq_q <= irq_set || (irq_q && |fstat_q);

         frst_q <= func_fire;
         drst_q <= dest_fire;
      end
   end

   assign func_reset_o = frst_q;
   assign dest_reset_o = drst_q;
   assign hold_o       = hold_q;
   assign irq_o        = irq_q;

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFS_DSTAT): bus_rdata[DST_W-1:0]    = dstat_q;
         ADDR_W'(OFS_FSTAT): bus_rdata[NUM_FUNC-1:0] = fstat_q;
         ADDR_W'(OFS_FDIS):  bus_rdata[NUM_FUNC-1:0] = fdis_q;
         ADDR_W'(OFS_FCNT):  bus_rdata[CNT_W-1:0]    = fcnt_q;
         ADDR_W'(OFS_FTHR):  bus_rdata[CNT_W-1:0]    = fthr_q;
         ADDR_W'(OFS_DTHR):  bus_rdata[CNT_W-1:0]    = dthr_q;
         default:            bus_rdata = '0;
      endcase
   end

   // ---------------- assertions ----------------
   assert_hold_until_por_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && !d_rise[0]) |=> hold_q)
      else $error("hold released without power-on");

   assert_quiet_while_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hold_q |=> !(func_reset_o || dest_reset_o))
      else $error("reset pulse issued while held");

   assert_one_class_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(func_reset_o && dest_reset_o))
      else $error("both reset classes issued together");

   assert_dest_reloads_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dest_reset_o |-> (fthr_q == CNT_MAX && fcnt_q == '0))
      else $error("destructive reset left functional state");

   assert_irq_from_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(wr_fdis))
      else $error("flag rose without a disable write");

endmodule

// File: tb/rst_esc_unit_test.sv
module rst_esc_unit_test;

   localparam int K_REG = 0, K_FRST = 1, K_DRST = 2, K_HOLD = 3, K_IRQ = 4;

   typedef struct {
      int          kind;
      logic [31:0] exp;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        por_lvl = 1'b0;
   logic [2:0]  dest_lvl = '0;
   logic [3:0]  func_lvl = '0;
   logic        bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        func_reset_o, dest_reset_o, hold_o, irq_o;

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   item_t q[$];

   rst_esc_unit uut (
      .clk(clk), .rst_n(rst_n), .por_lvl(por_lvl), .dest_lvl(dest_lvl),
      .func_lvl(func_lvl), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .func_reset_o(func_reset_o), .dest_reset_o(dest_reset_o),
      .hold_o(hold_o), .irq_o(irq_o));

   always #5 clk = ~clk;

   // monitor: compares queued expectations 2 ns after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
               K_REG:   act = bus_rdata;
               K_FRST:  act = {31'b0, func_reset_o};
               K_DRST:  act = {31'b0, dest_reset_o};
               K_HOLD:  act = {31'b0, hold_o};
               default: act = {31'b0, irq_o};
            endcase
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s kind=%0d actual=%0h expected=%0h", it.tag, it.kind, act, it.exp);
            end
         end
      end
   end

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic push(int k, logic [31:0] e, string t);
      item_t it;
      it.kind = k;
      it.exp  = e;
      it.tag  = t;
      q.push_back(it);
   endtask

   task automatic rd(logic [5:0] a, logic [31:0] e, string t);
      bus_addr = a;
      push(K_REG, e, t);
      tick();
   endtask

   task automatic wr(logic [5:0] a, logic [31:0] d);
      bus_we = 1'b1;
      bus_addr = a;
      bus_wdata = d;
      tick();
      bus_we = 1'b0;
   endtask

   task automatic outs(logic f, logic d, string t);
      push(K_FRST, {31'b0, f}, t);
      push(K_DRST, {31'b0, d}, t);
   endtask

   task automatic fev(int i, logic f, logic d, string t);
      func_lvl[i] = 1'b1;
      tick();
      func_lvl[i] = 1'b0;
      outs(f, d, t);
      tick();
   endtask

   task automatic dev(int i, logic d, string t);
      dest_lvl[i] = 1'b1;
      tick();
      dest_lvl[i] = 1'b0;
      outs(1'b0, d, t);
      tick();
   endtask

   task automatic por();
      por_lvl = 1'b1;
      tick();
      por_lvl = 1'b0;
      outs(1'b0, 1'b0, "R8 power-on issues no pulse");
      tick();
   endtask

   // watchdog
   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1 reset values, R2 map
      rd(6'h00, 32'h0,  "R1 dstat");
      rd(6'h08, 32'h0,  "R1 fstat");
      rd(6'h14, 32'h0,  "R1 fcnt");
      rd(6'h18, 32'hF,  "R1 fthr");
      rd(6'h1C, 32'h0,  "R1 dthr");
      rd(6'h04, 32'h0,  "R2 unmapped offset");
      push(K_HOLD, 0, "R1 hold");
      push(K_IRQ, 0, "R1 irq");
      outs(1'b0, 1'b0, "R1 pulses");
      tick();

      // R8 power-on status, R9 clear when inactive
      por();
      rd(6'h00, 32'h1, "R8 por status bit");
      wr(6'h00, 32'h1);
      rd(6'h00, 32'h0, "R9 clear idle por bit");

      // R3 functional event
      fev(0, 1'b1, 1'b0, "R3 func pulse");
      rd(6'h14, 32'h1, "R3 count one");
      rd(6'h08, 32'h1, "R2 external bit");

      // R9 clear blocked while source high
      func_lvl[2] = 1'b1;
      tick();
      outs(1'b1, 1'b0, "R3 second func");
      wr(6'h08, 32'h5);
      rd(6'h08, 32'h4, "R9 busy bit kept");
      func_lvl[2] = 1'b0;
      tick();
      wr(6'h08, 32'h4);
      rd(6'h08, 32'h0, "R9 bit cleared after release");

      // R5 limit zero, R3 saturation
      wr(6'h18, 32'h0);
      for (int i = 0; i < 20; i++) fev(1, 1'b1, 1'b0, "R5 no escalation");
      rd(6'h14, 32'hF, "R3 count saturates");

      // R4 escalation, R7 reload
      wr(6'h18, 32'h3);
      fev(0, 1'b0, 1'b1, "R4 promoted");
      rd(6'h14, 32'h0, "R7 count cleared");
      rd(6'h18, 32'hF, "R7 limit reloaded");
      rd(6'h00, 32'h10, "R4 escalation bit");
      wr(6'h18, 32'h2);
      fev(0, 1'b1, 1'b0, "R4 below limit");
      fev(0, 1'b0, 1'b1, "R4 at limit");

      // R6 hold, R7 dthr untouched (destructive count now 2)
      wr(6'h1C, 32'h5);
      dev(0, 1'b1, "R7 direct destructive");
      rd(6'h1C, 32'h5, "R7 dthr kept");
      dev(1, 1'b1, "R6 count four");
      push(K_HOLD, 0, "R6 below limit");
      tick();
      dev(2, 1'b1, "R6 count five");
      push(K_HOLD, 1, "R6 hold set");
      tick();
      fev(3, 1'b0, 1'b0, "R6 func ignored while held");
      dev(0, 1'b0, "R6 dest ignored while held");
      push(K_HOLD, 1, "R6 hold sticky");
      tick();

      // R8 power-on release
      por();
      push(K_HOLD, 0, "R8 hold released");
      rd(6'h00, 32'h1, "R8 dstat only por");
      rd(6'h08, 32'h0, "R8 fstat cleared");
      rd(6'h14, 32'h0, "R8 fcnt");
      rd(6'h18, 32'hF, "R8 fthr");
      rd(6'h1C, 32'h0, "R8 dthr");

      // R11 destructive count saturation
      for (int i = 0; i < 20; i++) dev(i % 3, 1'b1, "R11 dest pulse");
      push(K_HOLD, 0, "R11 no hold with zero limit");
      tick();
      wr(6'h1C, 32'hF);
      dev(0, 1'b1, "R11 dest at top");
      push(K_HOLD, 1, "R11 saturated count holds");
      tick();
      por();

      // R12 priority
      fev(0, 1'b1, 1'b0, "R12 setup func");
      func_lvl[1] = 1'b1;
      dest_lvl[1] = 1'b1;
      tick();
      func_lvl[1] = 1'b0;
      dest_lvl[1] = 1'b0;
      outs(1'b0, 1'b1, "R12 dest over func");
      tick();
      rd(6'h14, 32'h0, "R12 func count cleared");
      por_lvl = 1'b1;
      dest_lvl[0] = 1'b1;
      tick();
      por_lvl = 1'b0;
      dest_lvl[0] = 1'b0;
      outs(1'b0, 1'b0, "R12 power over dest");
      tick();
      rd(6'h00, 32'h3, "R12 status after power and dest");

      // R10 flag
      fev(1, 1'b1, 1'b0, "R10 setup");
      rd(6'h08, 32'h2, "R10 fstat");
      wr(6'h0C, 32'h1);
      push(K_IRQ, 0, "R10 no flag when status clear");
      tick();
      wr(6'h0C, 32'h2);
      push(K_IRQ, 1, "R10 flag raised");
      rd(6'h0C, 32'h2, "R10 disable readback");
      wr(6'h08, 32'h2);
      tick();
      push(K_IRQ, 0, "R10 flag dropped");
      tick();

      tick();
      tick();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule